// File: doc/BRIEF.md
# Control OUT Endpoint 0 Handshake Register

This block holds the control and status word of a USB device's control OUT endpoint 0 and picks the handshake for each OUT or SETUP packet that arrives on that endpoint. Software reaches the word through a plain register port with write and read strobes, an address and byte enables. The packet engine reports four events: SETUP token seen, SETUP data packet received, transfer completed and bus reset. The block returns the handshake to send and a few level and pulse outputs.

Several command bits act only when written as 1, and some are pure commands that never read back. Hardware events set or clear the same flags, so every flag has a fixed rule for what wins when software and hardware act in the same cycle. The handshake follows a fixed priority. A SETUP data packet is always acknowledged. Otherwise STALL comes before NAK, and NAK comes before ACK.

The block carries no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. Writes take effect at the next clock edge. Reads are combinational.

Top module: `ep0_out_ctrl`

## Requirements
- R1: Writing 1 to bit 31 with byte enable 3 set turns on the endpoint enable (`ep_enable`). Writing 0 there leaves it unchanged.
- R2: A transfer-completed or SETUP-packet event clears the enable at the next edge, and this clear beats a same-cycle software set. `irq_xfer_done` or `irq_setup_done` pulses for one cycle from that same edge, so the enable already reads 0 while the pulse is high.
- R3: Bit 30, bits 27:26, bits 19:18 and all unassigned bits read 0. A read to any address other than the register's reads all zeros, and a write to any other address changes nothing.
- R4: Writing 1 to bit 27 (byte enable 3) sets the internal NAK flag, and writing 1 to bit 26 clears it. When both are written together, the flag ends set.
- R5: A transfer-completed or SETUP-packet event sets the NAK flag, and this wins over a same-cycle software clear.
- R6: Writing 1 to bit 21 (byte enable 2) sets STALL, and writing 0 there leaves it unchanged. A SETUP token event clears STALL, and this clear wins over a same-cycle set.
- R7: `hs_code` uses the encoding ACK=00, NAK=01, STALL=10. For a non-SETUP packet the code is STALL if STALL is set. Otherwise it is NAK if the NAK flag or `glob_out_nak` is set. Otherwise it is ACK.
- R8: While `pkt_is_setup` is 1, `hs_code` is ACK whatever STALL, NAK and `glob_out_nak` hold.
- R9: Bit 20 is a read/write snoop bit written under byte enable 2, and it drives `snoop_en`.
- R10: `nak_status` and read bit 17 are 1 exactly when a non-SETUP packet would get NAK.
- R11: A `ev_bus_reset` event, or `rst_n` low, returns the enable, NAK, STALL and snoop bits and both interrupt pulses to 0. A bus reset wins over every same-cycle write or event.
- R12: A write only touches a bit when the byte enable for that bit's lane is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_addr | input | 4 | Register address |
| csr_wdata | input | 32 | Write data |
| csr_be | input | 4 | Byte enables |
| csr_rdata | output | 32 | Read data; zero unless a read hits the register |
| ev_setup_tok | input | 1 | SETUP token seen on endpoint 0 |
| ev_setup_pkt | input | 1 | SETUP data packet received |
| ev_xfer_done | input | 1 | OUT transfer completed |
| ev_bus_reset | input | 1 | USB bus reset detected |
| glob_out_nak | input | 1 | Device-wide OUT NAK request |
| pkt_is_setup | input | 1 | Packet under decision is a SETUP data packet |
| hs_code | output | 2 | Handshake: 00 ACK, 01 NAK, 10 STALL |
| ep_enable | output | 1 | Endpoint enable bit |
| nak_status | output | 1 | Non-SETUP packets are being NAKed |
| snoop_en | output | 1 | Skip the packet-correctness check |
| irq_setup_done | output | 1 | One-cycle SETUP-stage-done pulse |
| irq_xfer_done | output | 1 | One-cycle transfer-completed pulse |

## Verification
The hardest states to reach are collisions in a single cycle:
- a Clear NAK write against a hardware NAK set;
- a STALL set write against a SETUP token;
- Set NAK and Clear NAK written together;
- a bus reset on top of any of these.

Random traffic reaches these only rarely. The stimulus therefore drives each collision directly, then runs several thousand random cycles. In these cycles event rates are raised and byte enables and addresses are varied, so the collisions recur against many different flag states.

// File: rtl/ep0_out_pkg.sv
package ep0_out_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10
  } hs_e;

  localparam int BIT_EN     = 31;
  localparam int BIT_SNAK   = 27;
  localparam int BIT_CNAK   = 26;
  localparam int BIT_STALL  = 21;
  localparam int BIT_SNOOP  = 20;
  localparam int BIT_NAKSTS = 17;

  typedef struct packed {
    logic set_en;
    logic set_nak;
    logic clr_nak;
    logic set_stall;
    logic wr_snoop;
    logic snoop_val;
  } sw_cmd_t;

  typedef struct packed {
    logic en;
    logic nak;
    logic stall;
    logic snoop;
  } ep_state_t;
endpackage

// File: rtl/ep0_csr_if.sv
module ep0_csr_if
  import ep0_out_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CSR_ADDR = '0
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/8-1:0] be,
  input  ep_state_t         st,
  input  logic              naksts,
  output sw_cmd_t           cmd,
  output logic [DATA_W-1:0] rdata
);
  localparam int NLANE = DATA_W / 8;

  logic             hit;
  logic [NLANE-1:0] lane_we;
  logic             unused_wbits;

  assign hit = (addr == CSR_ADDR);

  generate
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      assign lane_we[i] = wr & hit & be[i];
    end
  endgenerate

  assign unused_wbits = ^{wdata, lane_we};

  always_comb begin
    cmd.set_en    = lane_we[BIT_EN/8]    & wdata[BIT_EN];
    cmd.set_nak   = lane_we[BIT_SNAK/8]  & wdata[BIT_SNAK];
    cmd.clr_nak   = lane_we[BIT_CNAK/8]  & wdata[BIT_CNAK];
    cmd.set_stall = lane_we[BIT_STALL/8] & wdata[BIT_STALL];
    cmd.wr_snoop  = lane_we[BIT_SNOOP/8];
    cmd.snoop_val = wdata[BIT_SNOOP];
  end

  always_comb begin
    rdata = '0;
    if (rd && hit) begin
      rdata[BIT_EN]     = st.en;
      rdata[BIT_STALL]  = st.stall;
      rdata[BIT_SNOOP]  = st.snoop;
      rdata[BIT_NAKSTS] = naksts;
    end
  end
endmodule

// File: rtl/ep0_state.sv
module ep0_state
  import ep0_out_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sw_cmd_t   cmd,
  input  logic      ev_setup_tok,
  input  logic      ev_setup_pkt,
  input  logic      ev_xfer_done,
  input  logic      ev_bus_reset,
  output ep_state_t st_q,
  output logic      irq_setup_q,
  output logic      irq_xfer_q
);
  logic hw_done;
  assign hw_done = ev_setup_pkt | ev_xfer_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= '0;
      irq_setup_q <= 1'b0;
      irq_xfer_q  <= 1'b0;
    end else if (ev_bus_reset) begin
      st_q        <= '0;
      irq_setup_q <= 1'b0;
      irq_xfer_q  <= 1'b0;
    end else begin
      irq_setup_q <= ev_setup_pkt;
      irq_xfer_q  <= ev_xfer_done;
      if (hw_done)         st_q.en <= 1'b0;
      else if (cmd.set_en) st_q.en <= 1'b1;
      if (hw_done || cmd.set_nak) st_q.nak <= 1'b1;
      else if (cmd.clr_nak)       st_q.nak <= 1'b0;
      if (ev_setup_tok)       st_q.stall <= 1'b0;
      else if (cmd.set_stall) st_q.stall <= 1'b1;
      if (cmd.wr_snoop) st_q.snoop <= cmd.snoop_val;
    end
  end
endmodule

// File: rtl/ep0_hs_arb.sv
module ep0_hs_arb
  import ep0_out_pkg::*;
(
  input  logic stall,
  input  logic nak,
  input  logic glob_nak,
  input  logic is_setup,
  output hs_e  hs,
  output logic naksts
);
  assign naksts = !stall && (nak || glob_nak);

  always_comb begin
    if (is_setup)    hs = HS_ACK;
    else if (stall)  hs = HS_STALL;
    else if (naksts) hs = HS_NAK;
    else             hs = HS_ACK;
  end
endmodule

// File: rtl/ep0_out_ctrl.sv
module ep0_out_ctrl
  import ep0_out_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 4'h8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic                csr_rd,
  input  logic [ADDR_W-1:0]   csr_addr,
  input  logic [DATA_W-1:0]   csr_wdata,
  input  logic [DATA_W/8-1:0] csr_be,
  output logic [DATA_W-1:0]   csr_rdata,
  input  logic                ev_setup_tok,
  input  logic                ev_setup_pkt,
  input  logic                ev_xfer_done,
  input  logic                ev_bus_reset,
  input  logic                glob_out_nak,
  input  logic                pkt_is_setup,
  output logic [1:0]          hs_code,
  output logic                ep_enable,
  output logic                nak_status,
  output logic                snoop_en,
  output logic                irq_setup_done,
  output logic                irq_xfer_done
);
  sw_cmd_t   cmd;
  ep_state_t st_q;
  hs_e       hs;
  logic      stall_q;
  logic      nak_q;

  ep0_csr_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_csr (
    .wr(csr_wr), .rd(csr_rd), .addr(csr_addr), .wdata(csr_wdata), .be(csr_be),
    .st(st_q), .naksts(nak_status), .cmd(cmd), .rdata(csr_rdata)
  );

  ep0_state u_state (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .ev_setup_tok(ev_setup_tok), .ev_setup_pkt(ev_setup_pkt),
    .ev_xfer_done(ev_xfer_done), .ev_bus_reset(ev_bus_reset),
    .st_q(st_q), .irq_setup_q(irq_setup_done), .irq_xfer_q(irq_xfer_done)
  );

  assign stall_q = st_q.stall;
  assign nak_q   = st_q.nak;

  ep0_hs_arb u_arb (
    .stall(stall_q), .nak(nak_q), .glob_nak(glob_out_nak),
    .is_setup(pkt_is_setup), .hs(hs), .naksts(nak_status)
  );

  assign hs_code   = hs;
  assign ep_enable = st_q.en;
  assign snoop_en  = st_q.snoop;
endmodule

// File: rtl/ep0_out_ctrl_chk.sv
module ep0_out_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_setup_tok,
  input logic       ev_setup_pkt,
  input logic       ev_xfer_done,
  input logic       ev_bus_reset,
  input logic       pkt_is_setup,
  input logic [1:0] hs_code,
  input logic       ep_enable,
  input logic       snoop_en,
  input logic       irq_setup_done,
  input logic       irq_xfer_done,
  input logic       stall_q,
  input logic       nak_q
);
  p_en_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_setup_done || irq_xfer_done) |-> !ep_enable);

  p_hw_nak_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_xfer_done || ev_setup_pkt) && !ev_bus_reset) |=> nak_q);

  p_tok_clr_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup_tok |=> !stall_q);

  p_stall_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !pkt_is_setup) |-> hs_code == 2'b10);

  p_setup_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_is_setup |-> hs_code == 2'b00);

  p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_reset |=> (!ep_enable && !nak_q && !stall_q && !snoop_en
                      && !irq_setup_done && !irq_xfer_done));
endmodule

bind ep0_out_ctrl ep0_out_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_setup_tok(ev_setup_tok),
  .ev_setup_pkt(ev_setup_pkt), .ev_xfer_done(ev_xfer_done),
  .ev_bus_reset(ev_bus_reset), .pkt_is_setup(pkt_is_setup),
  .hs_code(hs_code), .ep_enable(ep_enable), .snoop_en(snoop_en),
  .irq_setup_done(irq_setup_done), .irq_xfer_done(irq_xfer_done),
  .stall_q(stall_q), .nak_q(nak_q)
);

// File: tb/ep0_out_ctrl_tb.sv
module ep0_out_ctrl_tb;
  localparam logic [3:0] CSR = 4'h8;

  logic        clk = 0, rst_n = 0;
  logic        csr_wr = 0, csr_rd = 1;
  logic [3:0]  csr_addr = CSR;
  logic [31:0] csr_wdata = 0;
  logic [3:0]  csr_be = 0;
  logic [31:0] csr_rdata;
  logic        ev_setup_tok = 0, ev_setup_pkt = 0, ev_xfer_done = 0, ev_bus_reset = 0;
  logic        glob_out_nak = 0, pkt_is_setup = 0;
  logic [1:0]  hs_code;
  logic        ep_enable, nak_status, snoop_en, irq_setup_done, irq_xfer_done;

  int  n_chk = 0, n_fail = 0;
  bit  m_en, m_nak, m_stall, m_snoop, m_irq_s, m_irq_x;

  always #5 clk = ~clk;

  ep0_out_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hs(input bit ps, input bit gn);
    if (ps) return 2'b00;
    if (m_stall) return 2'b10;
    if (m_nak || gn) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_word(input logic [3:0] a, input bit gn);
    logic [31:0] w = '0;
    if (a != CSR) return '0;
    w[31] = m_en; w[21] = m_stall; w[20] = m_snoop;
    w[17] = !m_stall && (m_nak || gn);
    return w;
  endfunction

  task automatic check_all(input string tag);
    chk(ep_enable == m_en, {tag, " R1/R2 enable"}, ep_enable, m_en);
    chk(snoop_en == m_snoop, {tag, " R9 snoop"}, snoop_en, m_snoop);
    chk(irq_xfer_done == m_irq_x && irq_setup_done == m_irq_s, {tag, " R2 irq"},
        {irq_setup_done, irq_xfer_done}, {m_irq_s, m_irq_x});
    chk(hs_code == exp_hs(pkt_is_setup, glob_out_nak), {tag, " R7/R8 handshake"},
        hs_code, exp_hs(pkt_is_setup, glob_out_nak));
    chk(nak_status == (!m_stall && (m_nak || glob_out_nak)), {tag, " R10 nak status"},
        nak_status, !m_stall && (m_nak || glob_out_nak));
    chk(csr_rdata == exp_word(csr_addr, glob_out_nak), {tag, " R3/R4/R6 readback"},
        csr_rdata, exp_word(csr_addr, glob_out_nak));
  endtask

  task automatic cyc(input string tag, input bit wr, input logic [3:0] a, input logic [31:0] wd,
                     input logic [3:0] be, input bit st, input bit sp, input bit xd, input bit br,
                     input bit gn, input bit ps);
    bit hit, n_en, n_nak, n_stall, n_snoop;
    @(negedge clk);
    csr_wr = wr; csr_addr = a; csr_wdata = wd; csr_be = be;
    ev_setup_tok = st; ev_setup_pkt = sp; ev_xfer_done = xd; ev_bus_reset = br;
    glob_out_nak = gn; pkt_is_setup = ps;
    hit = wr && (a == CSR);
    n_en = m_en; n_nak = m_nak; n_stall = m_stall; n_snoop = m_snoop;
    if (sp || xd) n_en = 0; else if (hit && be[3] && wd[31]) n_en = 1;
    if (sp || xd || (hit && be[3] && wd[27])) n_nak = 1;
    else if (hit && be[3] && wd[26]) n_nak = 0;
    if (st) n_stall = 0; else if (hit && be[2] && wd[21]) n_stall = 1;
    if (hit && be[2]) n_snoop = wd[20];
    @(posedge clk); #1;
    if (br) begin
      m_en = 0; m_nak = 0; m_stall = 0; m_snoop = 0; m_irq_s = 0; m_irq_x = 0;
    end else begin
      m_en = n_en; m_nak = n_nak; m_stall = n_stall; m_snoop = n_snoop;
      m_irq_s = sp; m_irq_x = xd;
    end
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check_all("reset R11");
    @(negedge clk); rst_n = 1;
    // R1: writing 0 to enable has no effect, writing 1 sets it
    cyc("R1 zero", 1, CSR, 32'h0, 4'hF, 0,0,0,0, 0,0);
    cyc("R1 set",  1, CSR, 32'h8000_0000, 4'hF, 0,0,0,0, 0,0);
    // R12: lane 3 disabled blocks Set NAK
    cyc("R12 lane", 1, CSR, 32'h0800_0000, 4'h7, 0,0,0,0, 0,1);
    // R2: transfer done clears enable, beats concurrent set
    cyc("R2 clr", 1, CSR, 32'h8000_0000, 4'h8, 0,0,1,0, 0,0);
    // R5: hardware NAK set beats clear NAK
    cyc("R5 pre",  1, CSR, 32'h0400_0000, 4'h8, 0,0,0,0, 0,0);
    cyc("R5 race", 1, CSR, 32'h0400_0000, 4'h8, 0,1,0,0, 0,0);
    // R4: set and clear NAK together, set wins
    cyc("R4 clr",  1, CSR, 32'h0400_0000, 4'h8, 0,0,0,0, 0,0);
    cyc("R4 both", 1, CSR, 32'h0C00_0000, 4'h8, 0,0,0,0, 0,0);
    // R6/R7: stall over NAK and global NAK; R8 setup still ACK
    cyc("R6 set",   1, CSR, 32'h0020_0000, 4'h4, 0,0,0,0, 1,0);
    cyc("R8 setup", 0, CSR, 32'h0, 4'h0, 0,0,0,0, 1,1);
    cyc("R6 race",  1, CSR, 32'h0020_0000, 4'h4, 1,0,0,0, 0,0);
    // R3: mismatched address write ignored and read zero
    cyc("R3 addr", 1, 4'h3, 32'hFFFF_FFFF, 4'hF, 0,0,0,0, 0,0);
    cyc("R9 snoop", 1, CSR, 32'h0010_0000, 4'h4, 0,0,0,0, 0,0);
    // R11: bus reset beats writes
    cyc("R11 reset", 1, CSR, 32'hFFFF_FFFF, 4'hF, 0,0,1,1, 0,0);
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      a = ($urandom_range(7) == 0) ? 4'($urandom) : CSR;
      cyc("rand", $urandom_range(1), a, $urandom, 4'($urandom),
          $urandom_range(5) == 0, $urandom_range(7) == 0, $urandom_range(7) == 0,
          $urandom_range(40) == 0, $urandom_range(3) == 0, $urandom_range(4) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule